// File: doc/BRIEF.md
# Two-wire banked byte memory slave

This block is a slave on a two-wire serial bus (SCL clock, SDA open-drain data) that fronts a byte-wide memory split into two 32K banks. It runs on a fast system clock. Both bus lines pass through a flop synchronizer, and all bus activity is decoded from edges of the synchronized lines. The block recognises Start and Stop conditions and checks the first byte after a Start against a fixed device type and two select pins. That byte also supplies the bank bit and the transfer direction.

A write transfer carries two pointer bytes and then any number of data bytes. Each data byte is committed in the system clock cycle that follows its eighth bit, so the bus never has to wait for a write to finish. A read transfer returns bytes from the held 15-bit pointer for as long as the master acknowledges. The pointer wraps inside the selected bank, and a write-protect input refuses data bytes. The internal storage is a synchronous array of `2**IDX_AW` bytes, indexed by the bank bit and the low `IDX_AW-1` pointer bits.

Top module: `twb_bank_mem`

## Requirements
- R1: The first byte after a Start is accepted and acknowledged (SDA pulled low in the ninth clock) only when bits 7..4 equal 1010 and bits 3..2 equal `sel_i[1:0]`. Bit 1 is the bank bit and bit 0 selects read (1) or write (0).
- R2: A first byte that does not match is not acknowledged. Every later byte is ignored, with no acknowledge, no storage change and no pointer change, until the next Start.
- R3: In a write transfer the two bytes after the first byte are acknowledged and load the pointer: the low 7 bits of the first one become pointer bits 14..8 (its bit 7 is ignored), and the second one becomes bits 7..0. A transfer that stops after them only sets the pointer.
- R4: Each later write byte, sent MSB first, is stored at index {bank bit, pointer[IDX_AW-2:0]} and acknowledged.
- R5: After every data byte, written or read, the 15-bit pointer increments and wraps from 7FFFh to 0000h, so sequential transfers stay in the bank named by the first byte.
- R6: In a read transfer the block shifts out the byte at the current index MSB first, one bit per SCL low phase. It sends the next byte after each master acknowledge, and after a master no-acknowledge it releases SDA and ignores the bus until the next Start.
- R7: The pointer is held between transfers. A read with no pointer bytes starts at the held pointer and takes its bank from its own first byte.
- R8: While `wp_i` is high a write data byte is not acknowledged, not stored and does not advance the pointer. The pointer bytes are still acknowledged.
- R9: A Start at any point ends the current transfer and makes the next byte a first byte. A Start or Stop before the eighth bit of a write byte leaves storage unchanged. A Stop releases SDA.
- R10: `sda_oe` changes only while the synchronized SCL is low, so SDA is stable while SCL is high.
- R11: After reset SDA is released (`sda_oe` low).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sel_i | input | 2 | Device select pins, compared with first-byte bits 3..2 |
| wp_i | input | 1 | Write protect, refuses data bytes when high |

## Verification
Both banks are filled completely through sequential writes. The writes start at pointers that either cross the 7FFFh wrap or land on arbitrary in-bank offsets, and distinct data in each bank shows that the bank bit keeps the halves apart. Reads are made three ways: with newly loaded pointers, as current-address reads, and as sequential reads longer than a bank. These separate a pointer that is held from one that is reloaded, and an in-bank wrap from a carry into the bank bit. Protected writes, wrong device type, wrong select bits and bytes cut short by Start or Stop are each followed by a read-back, which shows that neither the storage nor the pointer moved.

// File: rtl/twb_pkg.sv
package twb_pkg;
  localparam int PTR_W = 15;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WR,
    ST_RD
  } twb_state_e;
endpackage

// File: rtl/twb_sync.sv
module twb_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '1;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/twb_cond.sv
module twb_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/twb_ram.sv
module twb_ram #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/twb_bank_mem.sv
module twb_bank_mem
  import twb_pkg::*;
#(
  parameter int IDX_AW      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [1:0] sel_i,
  input  logic       wp_i
);
  localparam int LOW_W = IDX_AW - 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  logic [1:0] sync_q;
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  twb_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_q), .d({scl_i, sda_i}), .q(sync_q)
  );
  assign scl_s = sync_q[1];
  assign sda_s = sync_q[0];

  twb_cond u_cond (
    .clk(clk), .rst_n(rst_q), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twb_state_e       st_q, st_d;
  logic [3:0]       cnt_q, cnt_d;
  logic [7:0]       shreg_q, shreg_d, obyte_q, obyte_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [6:0]       ahi_q, ahi_d;
  logic             bank_q, bank_d, rw_q, rw_d, ack_q, ack_d;
  logic             mack_q, mack_d, oe_q, oe_d;
  logic             mem_we;
  logic [7:0]       rx_byte, rdata;
  logic [IDX_AW-1:0] mem_addr;

  assign rx_byte  = {shreg_q[6:0], sda_s};
  assign mem_addr = {bank_q, ptr_q[LOW_W-1:0]};

  twb_ram #(.AW(IDX_AW)) u_ram (
    .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(rx_byte),
    .raddr(mem_addr), .rdata(rdata)
  );

  always_comb begin
    st_d = st_q;  cnt_d = cnt_q;  shreg_d = shreg_q;  obyte_d = obyte_q;
    ptr_d = ptr_q;  ahi_d = ahi_q;  bank_d = bank_q;  rw_d = rw_q;
    ack_d = ack_q;  mack_d = mack_q;  oe_d = oe_q;  mem_we = 1'b0;
    if (start_det) begin
      st_d = ST_DEV;  cnt_d = '0;  oe_d = 1'b0;
    end else if (stop_det) begin
      st_d = ST_IDLE; cnt_d = '0;  oe_d = 1'b0;
    end else if (scl_rise) begin
      case (st_q)
        ST_IDLE: ;
        ST_RD: begin
          if (cnt_q < 4'd9)  cnt_d = cnt_q + 4'd1;
          if (cnt_q == 4'd7) ptr_d = ptr_q + 15'd1;
          if (cnt_q == 4'd8) mack_d = ~sda_s;
        end
        default: begin
          if (cnt_q < 4'd9) cnt_d = cnt_q + 4'd1;
          if (cnt_q < 4'd8) shreg_d = rx_byte;
          if (cnt_q == 4'd7) begin
            ack_d = 1'b1;
            case (st_q)
              ST_DEV: begin
                if (rx_byte[7:4] == DEV_TYPE && rx_byte[3:2] == sel_i) begin
                  bank_d = rx_byte[1];
                  rw_d   = rx_byte[0];
                end else begin
                  st_d  = ST_IDLE;
                  ack_d = 1'b0;
                end
              end
              ST_AHI: ahi_d = rx_byte[6:0];
              ST_ALO: ptr_d = {ahi_q, rx_byte};
              ST_WR: begin
                if (wp_i) ack_d = 1'b0;
                else begin
                  mem_we = 1'b1;
                  ptr_d  = ptr_q + 15'd1;
                end
              end
              default: ;
            endcase
          end
        end
      endcase
    end else if (scl_fall) begin
      case (st_q)
        ST_IDLE: ;
        ST_RD: begin
          if (cnt_q == 4'd9) begin
            cnt_d = '0;
            if (mack_q) begin
              obyte_d = rdata;
              oe_d    = ~rdata[7];
            end else begin
              oe_d = 1'b0;
              st_d = ST_IDLE;
            end
          end else if (cnt_q == 4'd8) begin
            oe_d = 1'b0;
          end else if (cnt_q != 4'd0) begin
            obyte_d = {obyte_q[6:0], 1'b0};
            oe_d    = ~obyte_q[6];
          end
        end
        default: begin
          if (cnt_q == 4'd8) oe_d = ack_q;
          else if (cnt_q == 4'd9) begin
            oe_d  = 1'b0;
            cnt_d = '0;
            if (!ack_q) st_d = ST_IDLE;
            else begin
              case (st_q)
                ST_DEV: begin
                  if (rw_q) begin
                    st_d    = ST_RD;
                    obyte_d = rdata;
                    oe_d    = ~rdata[7];
                  end else st_d = ST_AHI;
                end
                ST_AHI:  st_d = ST_ALO;
                ST_ALO:  st_d = ST_WR;
                default: st_d = st_q;
              endcase
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st_q <= ST_IDLE;  cnt_q <= '0;  shreg_q <= '0;  obyte_q <= '0;
      ptr_q <= '0;  ahi_q <= '0;  bank_q <= 1'b0;  rw_q <= 1'b0;
      ack_q <= 1'b0;  mack_q <= 1'b0;  oe_q <= 1'b0;
    end else begin
      st_q <= st_d;  cnt_q <= cnt_d;  shreg_q <= shreg_d;  obyte_q <= obyte_d;
      ptr_q <= ptr_d;  ahi_q <= ahi_d;  bank_q <= bank_d;  rw_q <= rw_d;
      ack_q <= ack_d;  mack_q <= mack_d;  oe_q <= oe_d;
    end
  end

  assign sda_oe = oe_q;
endmodule

// File: rtl/twb_bank_mem_chk.sv
module twb_bank_mem_chk
  import twb_pkg::*;
(
  input logic             clk,
  input logic             arst_n,
  input logic             scl_s,
  input logic             sda_oe,
  input logic             start_det,
  input logic             stop_det,
  input logic             mem_we,
  input logic             wp_i,
  input twb_state_e       st,
  input logic [PTR_W-1:0] ptr
);
  a_r10_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!arst_n)
    !$stable(sda_oe) |-> !scl_s);

  a_r9_stop_releases: assert property (@(posedge clk) disable iff (!arst_n)
    stop_det |=> !sda_oe);

  a_r9_start_rearms: assert property (@(posedge clk) disable iff (!arst_n)
    start_det |=> (st == ST_DEV));

  a_r8_no_write_protected: assert property (@(posedge clk) disable iff (!arst_n)
    mem_we |-> !wp_i);

  a_r4_write_in_data_phase: assert property (@(posedge clk) disable iff (!arst_n)
    mem_we |-> (st == ST_WR));

  a_r5_ptr_steps_by_one: assert property (@(posedge clk) disable iff (!arst_n)
    ((ptr != $past(ptr)) && ($past(st) != ST_ALO)) |-> (ptr == $past(ptr) + 15'd1));
endmodule

bind twb_bank_mem twb_bank_mem_chk u_chk (
  .clk(clk), .arst_n(rst_q), .scl_s(scl_s), .sda_oe(sda_oe),
  .start_det(start_det), .stop_det(stop_det), .mem_we(mem_we),
  .wp_i(wp_i), .st(st_q), .ptr(ptr_q)
);

// File: tb/twb_bank_mem_test.sv
module twb_bank_mem_test;
  localparam int Q = 5;
  localparam logic [1:0] SEL = 2'b10;

  logic clk = 1'b0;
  logic rst_n, scl, mlow, wp, sda_oe, sda_bus;
  logic [1:0] sel;
  logic done = 1'b0;
  int nchk = 0, nerr = 0;
  logic [7:0] model [256];

  always #10 clk = ~clk;
  assign sda_bus = ~(mlow | sda_oe);
  assign sel = SEL;

  twb_bank_mem uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .sel_i(sel), .wp_i(wp)
  );

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    mlow = 1'b0; wq(); scl = 1'b1; wq(); mlow = 1'b1; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    mlow = 1'b1; wq(); scl = 1'b1; wq(); mlow = 1'b0; wq();
  endtask

  task automatic send_bit(input logic b);
    mlow = ~b; wq(); scl = 1'b1; wq(); scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    mlow = 1'b0; wq(); scl = 1'b1; wq();
    ack = ~sda_bus;
    scl = 1'b0; wq();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic s1;
    for (int i = 7; i >= 0; i--) begin
      mlow = 1'b0; wq(); scl = 1'b1;
      repeat (2) @(negedge clk);
      s1 = sda_bus;
      repeat (Q - 2) @(negedge clk);
      check("R10 sda stable while scl high", {31'd0, sda_bus}, {31'd0, s1});
      b[i] = sda_bus;
      scl = 1'b0; wq();
    end
    mlow = give_ack; wq(); scl = 1'b1; wq(); scl = 1'b0; wq(); mlow = 1'b0;
  endtask

  function automatic logic [7:0] pat(input logic bank, input int i);
    return 8'(i * 37 + (bank ? 91 : 0) + 5);
  endfunction

  function automatic logic [7:0] devb(input logic [3:0] ty, input logic [1:0] s,
                                      input logic bank, input logic rd);
    return {ty, s, bank, rd};
  endfunction

  task automatic write_seq(input logic bank, input logic [14:0] p0, input int n);
    logic ack;
    logic [14:0] p;
    p = p0;
    bus_start();
    send_byte(devb(4'b1010, SEL, bank, 1'b0), ack);
    check("R1 device byte ack", {31'd0, ack}, 32'd1);
    send_byte({1'b1, p0[14:8]}, ack);
    check("R3 pointer high ack", {31'd0, ack}, 32'd1);
    send_byte(p0[7:0], ack);
    check("R3 pointer low ack", {31'd0, ack}, 32'd1);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = pat(bank, i);
      send_byte(d, ack);
      check("R4 data ack", {31'd0, ack}, 32'd1);
      model[{bank, p[6:0]}] = d;
      p = p + 15'd1;
    end
    bus_stop();
  endtask

  task automatic read_cur(input logic bank, input logic [14:0] p0, input int n, input string rq);
    logic ack;
    logic [14:0] p;
    logic [7:0] b;
    p = p0;
    bus_start();
    send_byte(devb(4'b1010, SEL, bank, 1'b1), ack);
    check("R1 read device ack", {31'd0, ack}, 32'd1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      check(rq, {24'd0, b}, {24'd0, model[{bank, p[6:0]}]});
      p = p + 15'd1;
    end
    wq();
    check("R6 released after master nack", {31'd0, sda_oe}, 32'd0);
    bus_stop();
  endtask

  task automatic set_ptr(input logic bank, input logic [14:0] p0);
    logic ack;
    bus_start();
    send_byte(devb(4'b1010, SEL, bank, 1'b0), ack);
    check("R1 device ack", {31'd0, ack}, 32'd1);
    send_byte({1'b0, p0[14:8]}, ack);
    check("R3 high ack", {31'd0, ack}, 32'd1);
    send_byte(p0[7:0], ack);
    check("R3 low ack", {31'd0, ack}, 32'd1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] b;
    rst_n = 1'b0; scl = 1'b1; mlow = 1'b0; wp = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R11 sda released after reset", {31'd0, sda_oe}, 32'd0);

    // fill both banks; bank 0 crosses the 7FFFh wrap
    write_seq(1'b0, 15'h7FC0, 128);
    write_seq(1'b1, 15'h1234, 128);

    // current-address read: pointer held (12B4h), bank from new byte
    read_cur(1'b0, 15'h12B4, 3, "R7 current address read");

    // address-only write then sequential reads across wrap, both banks
    set_ptr(1'b0, 15'h7FFE);
    read_cur(1'b0, 15'h7FFE, 130, "R5 bank0 sequential wrap");
    set_ptr(1'b1, 15'h7FFE);
    read_cur(1'b1, 15'h7FFE, 130, "R5 bank1 sequential wrap");

    // write protect
    wp = 1'b1;
    set_ptr(1'b0, 15'h0010);
    send_byte(~model[8'h10], ack);
    check("R8 protected byte nack", {31'd0, ack}, 32'd0);
    bus_stop();
    wp = 1'b0;
    read_cur(1'b0, 15'h0010, 2, "R8 data and pointer unchanged");

    // mismatched device type and select bits
    bus_start();
    send_byte(devb(4'b1011, SEL, 1'b0, 1'b0), ack);
    check("R2 wrong type nack", {31'd0, ack}, 32'd0);
    send_byte(8'h00, ack);
    check("R2 later byte ignored", {31'd0, ack}, 32'd0);
    bus_stop();
    bus_start();
    send_byte(devb(4'b1010, ~SEL, 1'b0, 1'b0), ack);
    check("R2 wrong select nack", {31'd0, ack}, 32'd0);
    send_byte(8'h00, ack);
    check("R2 ignored high", {31'd0, ack}, 32'd0);
    send_byte(8'h10, ack);
    check("R2 ignored low", {31'd0, ack}, 32'd0);
    send_byte(~model[8'h12], ack);
    check("R2 ignored data", {31'd0, ack}, 32'd0);
    bus_stop();
    read_cur(1'b0, 15'h0012, 1, "R2 pointer and data untouched");

    // Start in the middle of a write byte
    set_ptr(1'b0, 15'h0020);
    for (int i = 0; i < 5; i++) send_bit(~model[8'h20][7 - i]);
    read_cur(1'b0, 15'h0020, 1, "R9 start abort keeps data");

    // Stop in the middle of a write byte
    set_ptr(1'b1, 15'h0030);
    for (int i = 0; i < 3; i++) send_bit(~model[8'hB0][7 - i]);
    bus_stop();
    wq();
    check("R9 stop releases sda", {31'd0, sda_oe}, 32'd0);
    set_ptr(1'b1, 15'h0030);
    read_cur(1'b1, 15'h0030, 1, "R9 stop abort keeps data");

    // single read of bank1 at a new offset
    set_ptr(1'b1, 15'h4455);
    bus_start();
    send_byte(devb(4'b1010, SEL, 1'b1, 1'b1), ack);
    check("R1 repeated start read ack", {31'd0, ack}, 32'd1);
    recv_byte(1'b0, b);
    check("R6 single byte read", {24'd0, b}, {24'd0, model[8'hD5]});
    bus_stop();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule